// File: doc/BRIEF.md
# Converter Calibration and Sample Capture Controller

This block sits on the host side of a 16-bit pipelined analog-to-digital converter. The converter has a self-calibration handshake and a parallel two's-complement output bus that can be tri-stated. The controller runs in the host clock domain. A one-cycle request makes it send a calibration-start pulse of fixed, legal width to the converter. It then follows the converter's calibration-done flag through a two-flop synchronizer: the flag must first go low and then come back high. A timeout bounds the whole wait.

Once calibration has finished, the controller drives the converter's output enable high. It synchronizes the converter's data-valid strobe and captures the data word and its out-of-range bit on each rising edge of that strobe. The pipeline holds stale words after a calibration, so a fixed number of the first strobes is discarded. Captured samples leave on a valid/ready stream. Four status outputs report: calibration in progress, calibrated, calibration timed out, and sample lost because the consumer stalled.

The data bus is sampled without a synchronizer. This relies on the converter holding each word stable for a full sample period, which is two converter clocks, while only the strobe is retimed.

Top module: `adc_calcap_ctrl`

## Requirements
- R1: After reset, conv_cal_start, conv_oe, m_valid and all four status outputs are low.
- R2: An accepted request drives conv_cal_start high for exactly PULSE_CYC consecutive clock cycles. PULSE_CYC must be at least 4. Each accepted request produces exactly one such pulse.
- R3: A cal_req that arrives while stat_busy is high is ignored. It produces no further start pulse and does not lengthen the calibration.
- R4: After the pulse, stat_busy stays high until the synchronized done flag has been seen low and then high. At that point stat_busy falls, and stat_ready and conv_oe rise.
- R5: If the done flag has not returned high within TIMEOUT_CYC cycles, counted from the first cycle of the start pulse, the block behaves as follows. stat_busy is high for exactly TIMEOUT_CYC cycles. stat_timeout is then set, and stat_ready and conv_oe stay low. stat_timeout clears on the next accepted request.
- R6: conv_oe is low from reset until a calibration completes. It is low during every calibration. m_valid is forced low while conv_oe is low.
- R7: After conv_oe rises, the first DROP_WORDS data-valid strobes are discarded. The next strobe's word is the first one delivered.
- R8: Each delivered sample carries the bus value captured after a rising strobe edge, bit-exact, with bit 15 as the two's-complement sign. It also carries that sample's out-of-range bit. Samples are delivered in strobe order.
- R9: While m_valid is high and m_ready is low, m_valid stays high and m_data and m_oor hold their values.
- R10: A strobe that arrives while a sample is pending and not accepted is dropped. The pending sample is kept and stat_overflow is set. stat_overflow stays set until the next accepted calibration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Synchronous calibration request |
| conv_cal_start | output | 1 | Calibration-start pulse to converter |
| conv_cal_done | input | 1 | Converter end-of-calibration flag, asynchronous |
| conv_oe | output | 1 | Converter output-bus enable |
| conv_dvalid | input | 1 | Converter data-valid strobe, asynchronous |
| conv_data | input | DATA_W | Converter two's-complement data bus |
| conv_oor | input | 1 | Converter out-of-range bit |
| m_valid | output | 1 | Stream sample valid |
| m_ready | input | 1 | Stream sample accepted |
| m_data | output | DATA_W | Stream sample word |
| m_oor | output | 1 | Stream sample out-of-range bit |
| stat_busy | output | 1 | Calibration in progress |
| stat_ready | output | 1 | Calibrated, capture enabled |
| stat_timeout | output | 1 | Last calibration timed out |
| stat_overflow | output | 1 | A sample was lost to a stalled consumer |

## Verification
The stand-in converter produces a ramp with a programmable start value and step. Three ramps are used.

- An ascending ramp crosses from positive full scale to negative full scale. It shows whether the sign bit and the out-of-range flag follow the raw bus.
- A large odd step spreads codes over the whole signed range and every bit position.
- A descending ramp passes through negative full scale.

Because the ramp index restarts at every calibration, the first delivered value shows exactly how many words were discarded. A stalled consumer separates "keep the pending word" from "overwrite it". A converter whose done flag never returns high sets the exact length of the busy window.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_PULSE = 2'd1,
    CS_WLOW  = 2'd2,
    CS_WHIGH = 2'd3
  } cal_state_e;
endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcc_cal_seq.sv
module adcc_cal_seq
  import adcc_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 8,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_s_i,
  output logic start_o,
  output logic busy_o,
  output logic ok_o,
  output logic tmo_o,
  output logic launch_o
);
  localparam int PCNT_W = $clog2(PULSE_CYC);
  localparam int TMR_W  = $clog2(TIMEOUT_CYC);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);

  cal_state_e        state_q, state_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              ok_q, ok_d;
  logic              tmo_q, tmo_d;
  logic              launch;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    tmr_d   = tmr_q;
    ok_d    = ok_q;
    tmo_d   = tmo_q;
    launch  = 1'b0;
    unique case (state_q)
      CS_IDLE: begin
        if (req_i) begin
          state_d = CS_PULSE;
          pcnt_d  = '0;
          tmr_d   = '0;
          ok_d    = 1'b0;
          tmo_d   = 1'b0;
          launch  = 1'b1;
        end
      end
      CS_PULSE: begin
        tmr_d = tmr_q + 1'b1;
        if (pcnt_q == PCNT_LAST) state_d = CS_WLOW;
        else                     pcnt_d  = pcnt_q + 1'b1;
      end
      CS_WLOW: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_LAST) begin
          state_d = CS_IDLE;
          tmo_d   = 1'b1;
        end else if (!done_s_i) begin
          state_d = CS_WHIGH;
        end
      end
      CS_WHIGH: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_LAST) begin
          state_d = CS_IDLE;
          tmo_d   = 1'b1;
        end else if (done_s_i) begin
          state_d = CS_IDLE;
          ok_d    = 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      pcnt_q  <= '0;
      tmr_q   <= '0;
      ok_q    <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      tmr_q   <= tmr_d;
      ok_q    <= ok_d;
      tmo_q   <= tmo_d;
    end
  end

  assign start_o  = (state_q == CS_PULSE);
  assign busy_o   = (state_q != CS_IDLE);
  assign ok_o     = ok_q;
  assign tmo_o    = tmo_q;
  assign launch_o = launch;

  // R4: calibrated status only rises while the retimed flag reads high
  a_r4_ok_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> done_s_i);
  // R5: a timeout always leaves the sequencer idle and uncalibrated
  a_r5_tmo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (state_q == CS_IDLE) && !ok_q);
endmodule

// File: rtl/adcc_capture.sv
module adcc_capture #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DROP_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              dv_s_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oor_i,
  input  logic              m_ready_i,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_oor_o,
  output logic              ovf_o
);
  localparam int DW = $clog2(DROP_WORDS + 2);
  localparam logic [DW-1:0] DROP_INIT = DW'(DROP_WORDS);

  logic              dv_prev_q;
  logic [DW-1:0]     drop_q, drop_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;
  logic              oor_q;
  logic              ovf_q, ovf_d;
  logic              strobe_edge, take, load_en;

  assign strobe_edge = dv_s_i & ~dv_prev_q;
  assign take        = en_i & strobe_edge & (drop_q == '0);
  assign load_en     = take & (~valid_q | m_ready_i);

  always_comb begin
    drop_d = drop_q;
    if (!en_i)                            drop_d = DROP_INIT;
    else if (strobe_edge && drop_q != '0) drop_d = drop_q - 1'b1;

    valid_d = valid_q;
    if (!en_i)                    valid_d = 1'b0;
    else if (load_en)             valid_d = 1'b1;
    else if (valid_q && m_ready_i) valid_d = 1'b0;

    ovf_d = ovf_q;
    if (clr_i)                             ovf_d = 1'b0;
    else if (take && valid_q && !m_ready_i) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_prev_q <= 1'b0;
      drop_q    <= DROP_INIT;
      valid_q   <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      dv_prev_q <= dv_s_i;
      drop_q    <= drop_d;
      valid_q   <= valid_d;
      ovf_q     <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oor_q  <= 1'b0;
    end else if (load_en) begin
      data_q <= data_i;
      oor_q  <= oor_i;
    end
  end

  assign m_valid_o = valid_q;
  assign m_data_o  = data_q;
  assign m_oor_o   = oor_q;
  assign ovf_o     = ovf_q;

  // R9: a stalled sample stays offered and unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && en_i) |=> m_valid_o && $stable(m_data_o) && $stable(m_oor_o));
  // R10: the lost-sample flag only clears through a new calibration
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);
  // R6: nothing is offered while capture is disabled
  a_r6_no_valid_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !m_valid_o);
endmodule

// File: rtl/adc_calcap_ctrl.sv
module adc_calcap_ctrl #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PULSE_CYC   = 8,
  parameter int unsigned TIMEOUT_CYC = 20000,
  parameter int unsigned DROP_WORDS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req,
  output logic              conv_cal_start,
  input  logic              conv_cal_done,
  output logic              conv_oe,
  input  logic              conv_dvalid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_oor,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_oor,
  output logic              stat_busy,
  output logic              stat_ready,
  output logic              stat_timeout,
  output logic              stat_overflow
);
  localparam int HW = $clog2(PULSE_CYC + 2) + 1;

  logic done_s, dv_s, cal_ok, launch;

  adcc_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d_i(conv_cal_done), .q_o(done_s));

  adcc_sync #(.STAGES(SYNC_STAGES)) u_sync_dv (
    .clk(clk), .rst_n(rst_n), .d_i(conv_dvalid), .q_o(dv_s));

  adcc_cal_seq #(.PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(cal_req), .done_s_i(done_s),
    .start_o(conv_cal_start), .busy_o(stat_busy), .ok_o(cal_ok),
    .tmo_o(stat_timeout), .launch_o(launch));

  adcc_capture #(.DATA_W(DATA_W), .DROP_WORDS(DROP_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .en_i(cal_ok), .clr_i(launch), .dv_s_i(dv_s),
    .data_i(conv_data), .oor_i(conv_oor), .m_ready_i(m_ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_oor_o(m_oor), .ovf_o(stat_overflow));

  assign conv_oe    = cal_ok;
  assign stat_ready = cal_ok;

  // Checker: length of the current start pulse
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt_q <= '0;
    else if (conv_cal_start) hi_cnt_q <= hi_cnt_q + 1'b1;
    else                     hi_cnt_q <= '0;
  end

  // R2: start pulse is exactly the configured width
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_cal_start) |-> hi_cnt_q == HW'(PULSE_CYC));
  // R3: a new pulse only begins from the idle sequencer
  a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_cal_start) |-> $past(!stat_busy));
  // R6: the converter bus is never enabled during calibration
  a_r6_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_oe |-> !stat_busy);
endmodule

// File: tb/sim_adc_calcap_ctrl.sv
`timescale 1ns/1ps
module sim_adc_calcap_ctrl;
  localparam int TMO = 600;
  localparam int PULSE = 8;
  localparam int DROP = 4;
  localparam int CAL_LEN = 300;

  logic clk = 1'b0;
  logic rst_n, cal_req, m_ready, hang;
  logic [15:0] base, step;
  logic conv_cal_start, conv_oe, m_valid, m_oor;
  logic stat_busy, stat_ready, stat_timeout, stat_overflow;
  logic [15:0] m_data;
  wire  [15:0] bus;
  wire         oor_bus;

  logic        mdl_done, mdl_dv, calib;
  logic [15:0] mdl_data;
  int          cal_cnt, idx;
  logic [2:0]  ph;

  int checks = 0, fails = 0;
  int got = 0, origin = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  assign bus     = conv_oe ? mdl_data : 16'hzzzz;
  assign oor_bus = conv_oe ? ((mdl_data == 16'h7FFF) || (mdl_data == 16'h8000)) : 1'bz;

  adc_calcap_ctrl #(.TIMEOUT_CYC(TMO), .PULSE_CYC(PULSE), .DROP_WORDS(DROP)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .conv_cal_start(conv_cal_start),
    .conv_cal_done(mdl_done), .conv_oe(conv_oe), .conv_dvalid(mdl_dv),
    .conv_data(bus), .conv_oor(oor_bus), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_oor(m_oor), .stat_busy(stat_busy), .stat_ready(stat_ready),
    .stat_timeout(stat_timeout), .stat_overflow(stat_overflow));

  // Stand-in converter: calibration handshake plus a strobe every 8 clocks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_done <= 1'b1; calib <= 1'b0; cal_cnt <= 0;
      ph <= 3'd0; idx <= 0; mdl_dv <= 1'b0; mdl_data <= 16'h0;
    end else begin
      if (conv_cal_start) begin
        mdl_done <= 1'b0; calib <= 1'b1; cal_cnt <= 0;
      end else if (calib && !hang) begin
        if (cal_cnt == CAL_LEN - 1) begin calib <= 1'b0; mdl_done <= 1'b1; end
        else cal_cnt <= cal_cnt + 1;
      end
      if (calib || conv_cal_start) begin
        ph <= 3'd0; idx <= 0; mdl_dv <= 1'b0;
      end else begin
        ph <= ph + 3'd1;
        if (ph == 3'd5) begin
          mdl_dv <= 1'b1; mdl_data <= base + 16'(idx) * step; idx <= idx + 1;
        end else if (ph == 3'd7) mdl_dv <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expw(input int k);
    return base + 16'(k) * step;
  endfunction

  // Stream monitor: R7 first index, R8 bit-exact order and out-of-range bit
  always @(negedge clk) begin
    if (mon_en && m_valid && m_ready) begin
      logic [15:0] e;
      e = expw(DROP + got - origin);
      chk(m_data == e, "R7/R8 data", int'(m_data), int'(e));
      chk(m_oor == ((e == 16'h7FFF) || (e == 16'h8000)), "R8 oor", int'(m_oor),
          int'((e == 16'h7FFF) || (e == 16'h8000)));
      got <= got + 1;
    end
  end

  task automatic pulse_req();
    @(posedge clk); #1 cal_req = 1'b1;
    @(posedge clk); #1 cal_req = 1'b0;
  endtask

  task automatic wait_idle(output int busy_cycles);
    busy_cycles = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (stat_busy) busy_cycles++;
      else if (i > 2) break;
    end
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (got - origin >= n) break;
    end
    chk(got - origin >= n, "R8 word count", got - origin, n);
  endtask

  initial begin
    int width, rises, bc;
    bit oe_bad, prev;
    rst_n = 1'b0; cal_req = 1'b0; m_ready = 1'b1; hang = 1'b0;
    base = 16'h7FF8; step = 16'h0001;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!conv_cal_start && !conv_oe && !m_valid, "R1 outputs", {conv_cal_start, conv_oe, m_valid}, 0);
    chk(!stat_busy && !stat_ready && !stat_timeout && !stat_overflow, "R1 status",
        {stat_busy, stat_ready, stat_timeout, stat_overflow}, 0);

    // First calibration, with a retrigger attempt while busy
    origin = got; mon_en = 1'b1;
    pulse_req();
    width = 0; rises = 0; oe_bad = 1'b0; prev = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (conv_cal_start) width++;
      if (conv_cal_start && !prev) rises++;
      prev = conv_cal_start;
      if (stat_busy && conv_oe) oe_bad = 1'b1;
      if (i == 20) cal_req = 1'b1;
      if (i == 21) cal_req = 1'b0;
      if (!stat_busy && i > 2) break;
    end
    chk(width == PULSE, "R2 pulse width", width, PULSE);
    chk(rises == 1, "R3 single pulse", rises, 1);
    chk(!oe_bad, "R6 oe during cal", oe_bad, 0);
    chk(stat_ready && conv_oe && !stat_timeout, "R4 completion", {stat_ready, conv_oe, stat_timeout}, 6);
    wait_words(24);

    // Recalibrate: wide odd step across the signed range
    mon_en = 1'b0;
    pulse_req();
    base = 16'h0000; step = 16'h0ABD;
    repeat (4) @(negedge clk);
    chk(!conv_oe && !m_valid && stat_busy, "R6 recal gating", {conv_oe, m_valid, stat_busy}, 1);
    origin = got; mon_en = 1'b1;
    wait_idle(bc);
    chk(stat_ready, "R4 recal done", stat_ready, 1);
    wait_words(48);

    // Stalled consumer
    @(posedge clk); #1 m_ready = 1'b0;
    mon_en = 1'b0;
    begin
      logic [15:0] held;
      held = expw(DROP + got - origin);
      repeat (44) @(negedge clk);
      chk(m_valid, "R9 valid held", m_valid, 1);
      chk(m_data == held, "R10 pending kept", int'(m_data), int'(held));
      chk(stat_overflow, "R10 overflow set", stat_overflow, 1);
      repeat (16) @(negedge clk);
      chk(m_data == held && stat_overflow, "R9 still held", int'(m_data), int'(held));
    end

    // Hung done flag: timeout
    hang = 1'b1;
    pulse_req();
    wait_idle(bc);
    chk(bc == TMO, "R5 busy length", bc, TMO);
    chk(stat_timeout && !stat_ready && !conv_oe, "R5 timeout status",
        {stat_timeout, stat_ready, conv_oe}, 4);
    chk(!stat_overflow, "R10 overflow cleared", stat_overflow, 0);
    chk(!m_valid, "R6 valid cleared", m_valid, 0);

    // Recover: descending through negative full scale
    hang = 1'b0; base = 16'h8006; step = 16'hFFFF;
    @(posedge clk); #1 m_ready = 1'b1;
    origin = got; mon_en = 1'b1;
    pulse_req();
    @(negedge clk);
    chk(!stat_timeout, "R5 timeout cleared", stat_timeout, 0);
    wait_idle(bc);
    chk(stat_ready && !stat_timeout, "R4 recovered", {stat_ready, stat_timeout}, 2);
    wait_words(16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule